// File: doc/BRIEF.md
# SD/MMC Command Path Controller

This block runs the command half of an SD/MMC host. Software loads a 32-bit argument and then writes a command word. That word holds a 6-bit command index, a 2-bit response mode, two marker bits for stop and data-start commands, and an enable bit. A write with the enable bit set serialises a 48-bit command frame onto the CMD line, most significant bit first. The frame carries a CRC7 that the block computes itself.

After the frame's end bit the block releases the line and listens for a response. It captures a short (48-bit) or long (136-bit) response into four response words and checks the CRC7 where the mode asks for it. Each outcome sets its own sticky status flag, and software clears any flag by writing a one to the same bit position of the clear register. The block advances one bit per `clk` cycle, so `clk` is the card clock. Clock division, the data lines and DMA belong to other blocks.

Register word addresses on `reg_addr`:
- 0: argument.
- 1: command.
- 2: status (read only).
- 3: clear (write only, reads 0).
- 4 to 7: response words 1 to 4.

Top module: `sdmmc_cmd_path`

## Requirements
- R1: A write to the command register (address 1) with bit 12 set starts a command, and CMD drive begins on the next cycle. A write with bit 12 clear returns the block to idle at once, releases the line and raises no flag.
- R2: The command frame is sent MSB first as: start bit 0, transmission bit 1, index (command bits [5:0]), the 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero seed) over the preceding 40 bits, and end bit 1. For example, index 0 with argument 0 gives the frame 0x400000000095.
- R3: `cmd_oe` is high for exactly the 48 frame cycles and low at all other times. While `cmd_oe` is low, `cmd_out` is 1.
- R4: With response mode 00 (command bits [9:8]), status bit 7 (sent) is set in the cycle after the end bit, and the block goes idle.
- R5: With mode 01, a 48-bit response starting with a 0 is received and its bits [39:8] are stored in response word 1. A matching CRC7 over the first 40 bits sets status bit 6 (response received). A mismatch sets status bit 0 (CRC fail) instead.
- R6: With mode 10, a short response is stored as in R5 and always sets status bit 6, whatever its CRC field holds.
- R7: With mode 11, a 136-bit response fills words 1 to 4 with frame bits [127:0], word 1 holding bits [127:96] and bit 0 of word 4 forced to 0. The CRC7 is checked over frame bits [127:8] against bits [7:1]. A match sets bit 6 and a mismatch sets bit 0.
- R8: If the line stays high for 64 cycles (RESP_TIMEOUT) after the end bit, status bit 2 (timeout) is set. A start bit arriving in the 64th cycle is still accepted.
- R9: Status flags are sticky. Writing the clear register (address 3) clears exactly the flags whose bit is 1 in the written data. After reset all flags are 0.
- R10: Status bit 11 reads 1 while a command or its response is in progress and 0 when idle.
- R11: The argument register reads back as written. The command register reads back bits [12:0] as written, including the stop marker (bit 7) and the data-start marker (bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one CMD bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable; line released when low |
| cmd_in | input | 1 | CMD line sampled value |

## Verification
The hardest conditions to reach from the ports are the exact edges of the response window and a corrupted long response. In both, the card side has to place a start bit or a single flipped CRC bit at a precise cycle relative to the block's own end bit. The bench captures the outgoing frame bit by bit to fix that reference. It then builds each response from its own CRC model, flips one CRC bit where needed, and sets the start-bit delay to 63 (accepted) or holds the line high across the window (timeout). It also samples the status one cycle before and one cycle after the window closes.

// File: rtl/sdmmc_cmd_path.sv
module sdmmc_cmd_path #(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  localparam int TW = $clog2(RESP_TIMEOUT + 1);
  localparam int FRAME_W = 48;
  localparam int LONG_W = 136;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} st_t;

  st_t          st;
  logic [31:0]  arg_q;
  logic [12:0]  cmd_q;
  logic [7:0]   flags;
  logic [7:0]   set_f;
  logic [31:0]  resp [4];
  logic [47:0]  tx_sh;
  logic [7:0]   bcnt;
  logic [TW-1:0] timer;
  logic [126:0] rx;
  logic [127:0] rx_nxt;
  logic         busy;

  function automatic logic [6:0] crc7_of(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      if (i < n) begin
        fb = d[i] ^ c[6];
        c  = {c[5:0], 1'b0};
        if (fb) c = c ^ 7'h09;
      end
    end
    return c;
  endfunction

  wire       wr_cmd = reg_wr && (reg_addr == 3'd1);
  wire       wr_arg = reg_wr && (reg_addr == 3'd0);
  wire       wr_clr = reg_wr && (reg_addr == 3'd3);
  wire [1:0] mode   = cmd_q[9:8];
  wire       is_long = (mode == 2'b11);
  wire       last_bit = (bcnt == (is_long ? 8'(LONG_W - 1) : 8'(FRAME_W - 1)));
  wire [6:0] tx_crc = crc7_of({80'b0, 2'b01, reg_wdata[5:0], arg_q}, 40);

  assign rx_nxt = {rx, cmd_in};
  wire [6:0] crc_s  = crc7_of({80'b0, rx_nxt[47:8]}, 40);
  wire [6:0] crc_l  = crc7_of(rx_nxt[127:8], 120);
  wire       crc_ok = (is_long ? crc_l : crc_s) == rx_nxt[7:1];
  wire       chk_crc = (mode != 2'b10);

  assign busy    = (st != S_IDLE);
  assign cmd_oe  = (st == S_SEND);
  assign cmd_out = cmd_oe ? tx_sh[47] : 1'b1;

  always_comb begin
    set_f = '0;
    if (!wr_cmd) begin
      if (st == S_SEND && bcnt == 8'(FRAME_W - 1) && mode == 2'b00) set_f[7] = 1'b1;
      if (st == S_WAIT && cmd_in && timer == TW'(RESP_TIMEOUT - 1)) set_f[2] = 1'b1;
      if (st == S_RECV && last_bit) begin
        if (chk_crc && !crc_ok) set_f[0] = 1'b1;
        else                    set_f[6] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      arg_q <= '0;
      cmd_q <= '0;
      flags <= '0;
      tx_sh <= '1;
      bcnt  <= '0;
      timer <= '0;
      rx    <= '0;
      for (int k = 0; k < 4; k++) resp[k] <= '0;
    end else begin
      flags <= (flags & ~(wr_clr ? reg_wdata[7:0] : 8'h00)) | set_f;
      if (wr_arg) arg_q <= reg_wdata;
      if (wr_cmd) begin
        cmd_q <= reg_wdata[12:0];
        bcnt  <= '0;
        if (reg_wdata[12]) begin
          st    <= S_SEND;
          tx_sh <= {2'b01, reg_wdata[5:0], arg_q, tx_crc, 1'b1};
        end else begin
          st    <= S_IDLE;
          tx_sh <= '1;
        end
      end else begin
        case (st)
          S_SEND: begin
            tx_sh <= {tx_sh[46:0], 1'b1};
            bcnt  <= bcnt + 8'd1;
            if (bcnt == 8'(FRAME_W - 1)) begin
              bcnt  <= '0;
              timer <= '0;
              st    <= (mode == 2'b00) ? S_IDLE : S_WAIT;
            end
          end
          S_WAIT: begin
            if (!cmd_in) begin
              st   <= S_RECV;
              bcnt <= 8'd1;
              rx   <= rx_nxt[126:0];
            end else if (timer == TW'(RESP_TIMEOUT - 1)) begin
              st <= S_IDLE;
            end else begin
              timer <= timer + 1'b1;
            end
          end
          S_RECV: begin
            rx   <= rx_nxt[126:0];
            bcnt <= bcnt + 8'd1;
            if (last_bit) begin
              st <= S_IDLE;
              if (is_long) begin
                resp[0] <= rx_nxt[127:96];
                resp[1] <= rx_nxt[95:64];
                resp[2] <= rx_nxt[63:32];
                resp[3] <= {rx_nxt[31:1], 1'b0};
              end else begin
                resp[0] <= rx_nxt[39:8];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = arg_q;
      3'd1:    reg_rdata = {19'b0, cmd_q};
      3'd2:    reg_rdata = {20'b0, busy, 3'b0, flags};
      3'd4:    reg_rdata = resp[0];
      3'd5:    reg_rdata = resp[1];
      3'd6:    reg_rdata = resp[2];
      3'd7:    reg_rdata = resp[3];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdmmc_cmd_path_chk.sv
module sdmmc_cmd_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        cmd_out,
  input logic        cmd_oe,
  input logic        cmd_in,
  input logic [7:0]  flags,
  input logic        busy
);
  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          oe_run <= '0;
    else if (reg_wr && reg_addr == 3'd1) oe_run <= '0;
    else if (cmd_oe)                     oe_run <= oe_run + 8'd1;
    else                                 oe_run <= '0;
  end

  p_start_on_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[12]));

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  p_drive_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (oe_run < 8'd48));

  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_oe && cmd_out));

  p_sent_after_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[7]) |-> $past(cmd_oe));

  p_timeout_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(!cmd_oe && cmd_in));

  p_single_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({$rose(flags[0]), $rose(flags[2]), $rose(flags[6]), $rose(flags[7])}));
endmodule

bind sdmmc_cmd_path sdmmc_cmd_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
  .flags(flags), .busy(busy)
);

// File: tb/sdmmc_cmd_path_tb.sv
`timescale 1ns/1ps
module sdmmc_cmd_path_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [47:0] cap;
  bit oe_gap;

  always #5 clk = ~clk;

  sdmmc_cmd_path u_dut (.*);

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [1:0]  mode;
    logic [7:0]  dly;
    logic        bad;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{6'd0,  32'h0000_0000, 2'b00, 8'd0,  1'b0, 8'h80},
    '{6'd8,  32'h0000_01AA, 2'b01, 8'd5,  1'b0, 8'h40},
    '{6'd17, 32'h0000_0000, 2'b01, 8'd0,  1'b1, 8'h01},
    '{6'd13, 32'h1234_0000, 2'b10, 8'd10, 1'b1, 8'h40},
    '{6'd55, 32'hCAFE_F00D, 2'b01, 8'd63, 1'b0, 8'h40},
    '{6'd1,  32'h40FF_8000, 2'b10, 8'd64, 1'b0, 8'h04}
  };

  function automatic logic [6:0] ref_crc(input logic [119:0] d, input int n);
    logic [6:0] r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic b = d[i] ^ r[6];
      r = {r[5:0], 1'b0} ^ (b ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic start_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] mode);
    wr(3'd0, arg);
    wr(3'd1, {19'b0, 1'b1, 2'b00, mode, 2'b00, idx});
    oe_gap = 1'b0;
    for (int j = 0; j < 48; j++) begin
      if (!cmd_oe) oe_gap = 1'b1;
      cap = {cap[46:0], cmd_out};
      @(negedge clk);
    end
  endtask

  task automatic respond(input logic [135:0] v, input int len, input int dly);
    for (int i = 0; i < dly; i++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int k = len - 1; k >= 0; k--) begin cmd_in = v[k]; @(negedge clk); end
    cmd_in = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] ef;
    logic [39:0] f;
    logic [6:0]  c;
    logic [31:0] pay;
    logic [119:0] cont;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd2, d);  chk(d == 32'h0, "R9 reset status", d, 0);
    chk(!cmd_oe && cmd_out, "R3 reset line released", {cmd_oe, cmd_out}, 2'b01);
    rd(3'd4, d);  chk(d == 32'h0, "R7 reset resp word", d, 0);

    // R11 readback, R1 no start without enable
    wr(3'd0, 32'h89AB_CDEF);
    rd(3'd0, d);  chk(d == 32'h89AB_CDEF, "R11 arg readback", d, 32'h89AB_CDEF);
    wr(3'd1, 32'h0000_02C5);
    rd(3'd1, d);  chk(d == 32'h0000_02C5, "R11 cmd readback markers", d, 32'h2C5);
    chk(!cmd_oe, "R1 no start with enable clear", cmd_oe, 0);
    rd(3'd2, d);  chk(d == 32'h0, "R10 idle after disabled write", d, 0);

    // table walk: R2 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      start_cmd(v.idx, v.arg, v.mode);
      ef = {2'b01, v.idx, v.arg, ref_crc({80'b0, 2'b01, v.idx, v.arg}, 40), 1'b1};
      chk(cap == ef && !oe_gap, "R2 frame", cap, ef);
      if (i == 0) chk(cap == 48'h400000000095, "R2 frame literal", cap, 48'h400000000095);
      chk(!cmd_oe, "R3 released after end bit", cmd_oe, 0);
      pay = v.arg ^ 32'hA5A5_0F0F;
      if (v.mode != 2'b00) begin
        if (v.dly >= 8'd64) repeat (70) @(negedge clk);
        else begin
          f = {2'b00, v.idx, pay};
          c = ref_crc({80'b0, f}, 40) ^ {6'b0, v.bad};
          respond({88'b0, f, c, 1'b1}, 48, int'(v.dly));
        end
      end
      rd(3'd2, d);
      chk(d[7:0] == v.exp && !d[11], "R4/R5/R6/R8 outcome flag", d, v.exp);
      if (v.exp[6]) begin
        rd(3'd4, d);
        chk(d == pay, "R5 short response word", d, pay);
      end
      wr(3'd3, 32'hFF);
      rd(3'd2, d);  chk(d == 32'h0, "R9 clear all", d, 0);
    end

    // R10 busy, R1 abort
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h0000_1111);
    repeat (10) @(negedge clk);
    rd(3'd2, d);  chk(d[11] && cmd_oe, "R10 busy during send", d, 32'h800);
    wr(3'd1, 32'h0);
    chk(!cmd_oe && cmd_out, "R1 abort releases line", {cmd_oe, cmd_out}, 2'b01);
    repeat (120) @(negedge clk);
    rd(3'd2, d);  chk(d == 32'h0, "R1 abort raises no flag", d, 0);

    // R8 exact window edge
    start_cmd(6'd13, 32'h0, 2'b10);
    repeat (63) @(negedge clk);
    rd(3'd2, d);  chk(d[2] == 1'b0 && d[11], "R8 no timeout at 63", d, 32'h800);
    @(negedge clk);
    rd(3'd2, d);  chk(d == 32'h4, "R8 timeout at 64", d, 32'h4);

    // R9 sticky and partial clear
    start_cmd(6'd0, 32'h0, 2'b00);
    rd(3'd2, d);  chk(d == 32'h84, "R9 flags accumulate", d, 32'h84);
    wr(3'd3, 32'h80);
    rd(3'd2, d);  chk(d == 32'h04, "R9 partial clear", d, 32'h04);
    wr(3'd3, 32'h04);
    rd(3'd2, d);  chk(d == 32'h0, "R9 final clear", d, 0);

    // R7 long response good, then bad CRC
    cont = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A};
    c = ref_crc(cont, 120);
    start_cmd(6'd9, 32'h0001_0000, 2'b11);
    respond({2'b00, 6'b111111, cont, c, 1'b1}, 136, 3);
    rd(3'd2, d);  chk(d == 32'h40, "R7 long ok flag", d, 32'h40);
    rd(3'd4, d);  chk(d == 32'hDEADBEEF, "R7 word1 msb", d, 32'hDEADBEEF);
    rd(3'd5, d);  chk(d == 32'h01234567, "R7 word2", d, 32'h01234567);
    rd(3'd6, d);  chk(d == 32'h89ABCDEF, "R7 word3", d, 32'h89ABCDEF);
    rd(3'd7, d);  chk(d == {24'h5A5A5A, c, 1'b0}, "R7 word4", d, {24'h5A5A5A, c, 1'b0});
    wr(3'd3, 32'hFF);
    start_cmd(6'd2, 32'h0, 2'b11);
    respond({2'b00, 6'b111111, cont, c ^ 7'h10, 1'b1}, 136, 0);
    rd(3'd2, d);  chk(d == 32'h01, "R7 long crc fail", d, 32'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule